// File: doc/BRIEF.md
# Time-of-Day Counter with Wildcard Alarm

This block keeps the time of day as seconds, minutes and hours and advances it by one second on each cycle where the one-second pulse `tick` is high. Software reads and writes the time as bytes. The byte format depends on two mode inputs. `bin_mode` selects plain binary bytes or BCD bytes, where the upper nibble holds the tens digit. `hr24` selects a 0–23 hour byte or a 12-hour byte whose top bit marks PM.

There are three alarm bytes, one each for seconds, minutes and hours. On every tick that advances the time, the block compares the advanced time with the alarm. The result appears on `alm_flag` in the same cycle as the update-ended pulse `upd_flag`. An alarm byte whose two top bits are both set is a wildcard and matches any value of its field.

The `hold` input is a set mode. It freezes the counters and blocks the alarm, but the update-ended pulse still appears on each tick. Time and alarm writes are accepted at any time.

Top module: `tod_alarm`

## Requirements
- R1: After synchronous reset the time is 00:00:00, every alarm byte is 0x00, and both flags are low. With `bin_mode`=0 and `hr24`=1 the three time outputs read 0x00.
- R2: On a cycle with `tick`=1, `hold`=0 and no time write, seconds advance by one. Seconds wrap from 59 (or above) to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. In 24-hour form, hours wrap from 23 to 0. The new time is visible the cycle after the tick.
- R3: With `bin_mode`=0, bytes are BCD, with the tens digit in bits 7:4 and the units digit in bits 3:0. With `bin_mode`=1, bytes hold the value directly. Writes are decoded, and outputs encoded, in the mode in force at that time.
- R4: With `hr24`=0, bit 7 of an hour byte means PM. A written hour is taken modulo 12 and has 12 added when bit 7 is set. On output, hour 0 reads as 12 and hours 12 to 23 set bit 7. The hour therefore runs 11 AM → 12 PM → 1 PM, and 11 PM → 12 AM.
- R5: `upd_flag` is high for exactly the cycle after each cycle with `tick`=1, whatever the value of `hold`.
- R6: `alm_flag` is high the cycle after a tick with `hold`=0 exactly when the advanced time matches every non-wildcard alarm field. `alm_flag` is never high without `upd_flag`.
- R7: An alarm byte with bits 7:6 equal to 2'b11 matches any value of its field. With all three alarm bytes set this way, every advancing tick raises `alm_flag`.
- R8: While `hold`=1, the counters do not advance and `alm_flag` stays low. Writes still take effect.
- R9: A time write in a tick cycle takes precedence. The counters take the written value and do not advance in that cycle.
- R10: Alarm bytes are stored raw. They are decoded with the BCD/binary and 12/24-hour modes in force at the time of comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second update pulse |
| hold | input | 1 | Set mode: freeze counters, block alarm |
| bin_mode | input | 1 | 1 = binary bytes, 0 = BCD bytes |
| hr24 | input | 1 | 1 = 24-hour, 0 = 12-hour with PM in bit 7 |
| time_we | input | 3 | Time write strobes: bit0 seconds, bit1 minutes, bit2 hours |
| alarm_we | input | 3 | Alarm write strobes: bit0 seconds, bit1 minutes, bit2 hours |
| wdata | input | 8 | Write byte |
| sec_q | output | 8 | Current seconds byte |
| min_q | output | 8 | Current minutes byte |
| hour_q | output | 8 | Current hours byte |
| upd_flag | output | 1 | Update-ended pulse |
| alm_flag | output | 1 | Alarm pulse |

## Verification
The checker watches several behaviours on every cycle:
- the update pulse follows each tick and no other cycle;
- the alarm pulse never appears without the update pulse, and never after a held tick;
- the outputs stay frozen under hold while the modes are unchanged;
- a binary seconds write reads back exactly.

Other behaviours depend on sequences of writes and ticks and only the bench scenarios show them:
- carry chains such as 23:59:59 → 00:00:00;
- the 12-hour PM transitions;
- BCD versus binary decoding;
- alarm matching with and without wildcards;
- alarm bytes re-read under a changed mode.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
    localparam int BYTE_W   = 8;
    localparam int FIELDS   = 3;
    localparam int F_SEC    = 0;
    localparam int F_MIN    = 1;
    localparam int F_HOUR   = 2;
    localparam int SEC_MAX  = 59;
    localparam int MIN_MAX  = 59;
    localparam int HOUR_MAX = 23;
    localparam int HALF_DAY = 12;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t hour;
        byte_t min;
        byte_t sec;
    } tod_t;

    typedef struct packed {
        logic bin;
        logic h24;
    } fmt_t;

    // Byte to value: BCD digits or plain binary.
    function automatic byte_t unpack_val(byte_t b, logic bin);
        byte_t tens;
        byte_t units;
        tens  = {4'b0, b[7:4]};
        units = {4'b0, b[3:0]};
        return bin ? b : byte_t'(tens * 8'd10 + units);
    endfunction

    // Value to byte: BCD digits or plain binary.
    function automatic byte_t pack_val(byte_t v, logic bin);
        byte_t t;
        byte_t u;
        t = v / 8'd10;
        u = v % 8'd10;
        return bin ? v : {t[3:0], u[3:0]};
    endfunction

    // Hour byte to 0..23 value; bit 7 is PM in 12-hour form.
    function automatic byte_t hour_from_byte(byte_t b, fmt_t f);
        byte_t v;
        if (f.h24) begin
            v = unpack_val(b, f.bin);
        end else begin
            v = unpack_val({1'b0, b[6:0]}, f.bin) % byte_t'(HALF_DAY);
            if (b[7]) v = v + byte_t'(HALF_DAY);
        end
        return v;
    endfunction

    // 0..23 value to hour byte.
    function automatic byte_t hour_to_byte(byte_t h, fmt_t f);
        byte_t h12;
        byte_t r;
        if (f.h24) begin
            r = pack_val(h, f.bin);
        end else begin
            h12 = h % byte_t'(HALF_DAY);
            if (h12 == '0) h12 = byte_t'(HALF_DAY);
            r = pack_val(h12, f.bin);
            r[7] = (h >= byte_t'(HALF_DAY));
        end
        return r;
    endfunction

    function automatic logic is_wild(byte_t b);
        return b[7:6] == 2'b11;
    endfunction
endpackage

// File: rtl/tod_counter.sv
module tod_counter
    import tod_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              hold,
    input  fmt_t              fmt,
    input  logic [FIELDS-1:0] time_we,
    input  byte_t             wdata,
    output tod_t              cur_q,
    output tod_t              nxt
);
    logic advance;
    assign advance = tick && !hold && !(|time_we);

    always_comb begin
        nxt = cur_q;
        if (|time_we) begin
            if (time_we[F_SEC])  nxt.sec  = unpack_val(wdata, fmt.bin);
            if (time_we[F_MIN])  nxt.min  = unpack_val(wdata, fmt.bin);
            if (time_we[F_HOUR]) nxt.hour = hour_from_byte(wdata, fmt);
        end else if (advance) begin
            if (cur_q.sec >= byte_t'(SEC_MAX)) begin
                nxt.sec = '0;
                if (cur_q.min >= byte_t'(MIN_MAX)) begin
                    nxt.min  = '0;
                    nxt.hour = (cur_q.hour >= byte_t'(HOUR_MAX)) ? '0 : cur_q.hour + 8'd1;
                end else begin
                    nxt.min = cur_q.min + 8'd1;
                end
            end else begin
                nxt.sec = cur_q.sec + 8'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt;
    end
endmodule

// File: rtl/tod_alarm_match.sv
module tod_alarm_match
    import tod_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  fmt_t              fmt,
    input  logic [FIELDS-1:0] alarm_we,
    input  byte_t             wdata,
    input  tod_t              probe,
    output logic              hit
);
    byte_t             alarm_q [FIELDS];
    byte_t             want    [FIELDS];
    byte_t             have    [FIELDS];
    logic [FIELDS-1:0] field_ok;

    assign have[F_SEC]  = probe.sec;
    assign have[F_MIN]  = probe.min;
    assign have[F_HOUR] = probe.hour;

    always_ff @(posedge clk) begin
        for (int f = 0; f < FIELDS; f++) begin
            if (rst)              alarm_q[f] <= '0;
            else if (alarm_we[f]) alarm_q[f] <= wdata;
        end
    end

    for (genvar f = 0; f < FIELDS; f++) begin : g_fld
        if (f == F_HOUR) begin : g_hr
            assign want[f] = hour_from_byte(alarm_q[f], fmt);
        end else begin : g_ms
            assign want[f] = unpack_val(alarm_q[f], fmt.bin);
        end
        assign field_ok[f] = is_wild(alarm_q[f]) || (want[f] == have[f]);
    end

    assign hit = &field_ok;
endmodule

// File: rtl/tod_alarm.sv
module tod_alarm
    import tod_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       hold,
    input  logic       bin_mode,
    input  logic       hr24,
    input  logic [2:0] time_we,
    input  logic [2:0] alarm_we,
    input  logic [7:0] wdata,
    output logic [7:0] sec_q,
    output logic [7:0] min_q,
    output logic [7:0] hour_q,
    output logic       upd_flag,
    output logic       alm_flag
);
    fmt_t fmt;
    tod_t cur;
    tod_t nxt;
    logic hit;

    assign fmt.bin = bin_mode;
    assign fmt.h24 = hr24;

    tod_counter u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .hold(hold), .fmt(fmt),
        .time_we(time_we), .wdata(wdata), .cur_q(cur), .nxt(nxt)
    );

    tod_alarm_match u_match (
        .clk(clk), .rst(rst), .fmt(fmt), .alarm_we(alarm_we),
        .wdata(wdata), .probe(nxt), .hit(hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_flag <= 1'b0;
            alm_flag <= 1'b0;
        end else begin
            upd_flag <= tick;
            alm_flag <= tick && !hold && hit;
        end
    end

    assign sec_q  = pack_val(cur.sec, fmt.bin);
    assign min_q  = pack_val(cur.min, fmt.bin);
    assign hour_q = hour_to_byte(cur.hour, fmt);
endmodule

// File: rtl/tod_alarm_chk.sv
module tod_alarm_chk (
    input logic       clk,
    input logic       rst,
    input logic       tick,
    input logic       hold,
    input logic       bin_mode,
    input logic       hr24,
    input logic [2:0] time_we,
    input logic [7:0] wdata,
    input logic [7:0] sec_q,
    input logic [7:0] min_q,
    input logic [7:0] hour_q,
    input logic       upd_flag,
    input logic       alm_flag
);
    AST_UPD_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        tick |=> upd_flag); // R5
    AST_UPD_ONLY_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> !upd_flag); // R5
    AST_ALM_NEEDS_UPD: assert property (@(posedge clk) disable iff (rst)
        alm_flag |-> upd_flag); // R6
    AST_HOLD_NO_ALARM: assert property (@(posedge clk) disable iff (rst)
        (tick && hold) |=> !alm_flag); // R8
    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (hold && time_we == 3'b000) |=>
        (!$stable(bin_mode) || !$stable(hr24) ||
         ($stable(sec_q) && $stable(min_q) && $stable(hour_q)))); // R8
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        (time_we[0] && bin_mode) |=> (!bin_mode || sec_q == $past(wdata))); // R9
endmodule

bind tod_alarm tod_alarm_chk u_chk (
    .clk(clk), .rst(rst), .tick(tick), .hold(hold), .bin_mode(bin_mode),
    .hr24(hr24), .time_we(time_we), .wdata(wdata), .sec_q(sec_q),
    .min_q(min_q), .hour_q(hour_q), .upd_flag(upd_flag), .alm_flag(alm_flag)
);

// File: tb/tod_alarm_test.sv
module tod_alarm_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, hold = 1'b0, bin_mode = 1'b0, hr24 = 1'b1;
    logic [2:0] time_we = '0, alarm_we = '0;
    logic [7:0] wdata = '0;
    logic [7:0] sec_q, min_q, hour_q;
    logic       upd_flag, alm_flag;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    int m_s = 0, m_m = 0, m_h = 0;
    int m_alm [3] = '{0, 0, 0};

    always #(CLK_PERIOD/2) clk = ~clk;

    tod_alarm uut (
        .clk(clk), .rst(rst), .tick(tick), .hold(hold), .bin_mode(bin_mode),
        .hr24(hr24), .time_we(time_we), .alarm_we(alarm_we), .wdata(wdata),
        .sec_q(sec_q), .min_q(min_q), .hour_q(hour_q),
        .upd_flag(upd_flag), .alm_flag(alm_flag)
    );

    function automatic int dec(int b, bit bin);
        return bin ? b : (b >> 4) * 10 + (b & 15);
    endfunction
    function automatic int hin(int b, bit bin, bit h24);
        if (h24) return dec(b, bin);
        return (dec(b & 127, bin) % 12) + (((b & 128) != 0) ? 12 : 0);
    endfunction
    function automatic int enc(int v, bit bin);
        return bin ? v : (((v / 10) << 4) | (v % 10));
    endfunction
    function automatic int hout(int h, bit bin, bit h24);
        int h12;
        if (h24) return enc(h, bin);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        return enc(h12, bin) | ((h >= 12) ? 128 : 0);
    endfunction
    function automatic bit wild(int b);
        return (b & 192) == 192;
    endfunction

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // One cycle of stimulus, reference update, then check of every output.
    task automatic step(bit tk, bit hd, bit [2:0] twe, bit [2:0] awe, int wd, string tag);
        bit e_alm;
        @(negedge clk);
        tick = tk; hold = hd; time_we = twe; alarm_we = awe; wdata = wd[7:0];
        if (twe != 0) begin
            if (twe[0]) m_s = dec(wd, bin_mode);
            if (twe[1]) m_m = dec(wd, bin_mode);
            if (twe[2]) m_h = hin(wd, bin_mode, hr24);
        end else if (tk && !hd) begin
            if (m_s >= 59) begin
                m_s = 0;
                if (m_m >= 59) begin m_m = 0; m_h = (m_h >= 23) ? 0 : m_h + 1; end
                else m_m++;
            end else m_s++;
        end
        e_alm = tk && !hd
              && (wild(m_alm[0]) || dec(m_alm[0], bin_mode) == m_s)
              && (wild(m_alm[1]) || dec(m_alm[1], bin_mode) == m_m)
              && (wild(m_alm[2]) || hin(m_alm[2], bin_mode, hr24) == m_h);
        for (int f = 0; f < 3; f++) if (awe[f]) m_alm[f] = wd & 255;
        @(posedge clk);
        #(CLK_PERIOD/4);
        chk({tag, " sec"},  sec_q,  enc(m_s, bin_mode));
        chk({tag, " min"},  min_q,  enc(m_m, bin_mode));
        chk({tag, " hour"}, hour_q, hout(m_h, bin_mode, hr24));
        chk({tag, " upd R5"}, upd_flag, tk);
        chk({tag, " alm R6"}, alm_flag, e_alm);
        tick = 0; hold = 0; time_we = 0; alarm_we = 0;
    endtask

    task automatic set_mode(bit bin, bit h24);
        @(negedge clk);
        bin_mode = bin; hr24 = h24;
    endtask

    task automatic set_time(int h, int m, int s);
        step(0, 0, 3'b100, 0, hout(h, bin_mode, hr24), "wr");
        step(0, 0, 3'b010, 0, enc(m, bin_mode), "wr");
        step(0, 0, 3'b001, 0, enc(s, bin_mode), "wr");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        #1;
        chk("R1 sec", sec_q, 8'h00);
        chk("R1 min", min_q, 8'h00);
        chk("R1 hour", hour_q, 8'h00);
        chk("R1 upd", upd_flag, 0);
        chk("R1 alm", alm_flag, 0);

        // R2 carry chain in BCD 24-hour form
        set_time(23, 59, 59);
        step(1, 0, 0, 0, 0, "R2 wrap");
        chk("R2 hour zero", hour_q, 8'h00);
        chk("R2 sec zero", sec_q, 8'h00);

        // R3 BCD versus binary
        step(0, 0, 3'b001, 0, 8'h45, "R3 bcd wr");
        chk("R3 bcd", sec_q, 8'h45);
        set_mode(1, 1);
        #1 chk("R3 bin view", sec_q, 8'h2D);
        step(1, 0, 0, 0, 0, "R3 bin tick");
        chk("R3 bin adv", sec_q, 8'h2E);

        // R4 12-hour transitions
        set_mode(0, 0);
        step(0, 0, 3'b100, 0, 8'h11, "R4 11am");
        set_time(11, 59, 59);
        step(1, 0, 0, 0, 0, "R4 noon");
        chk("R4 12pm", hour_q, 8'h92);
        set_time(12, 59, 59);
        step(1, 0, 0, 0, 0, "R4 1pm");
        chk("R4 1pm", hour_q, 8'h81);
        step(0, 0, 3'b100, 0, 8'h91, "R4 11pm wr");
        set_time(23, 59, 59);
        step(1, 0, 0, 0, 0, "R4 midnight");
        chk("R4 12am", hour_q, 8'h12);

        // R6 exact match
        set_mode(0, 1);
        set_time(10, 20, 29);
        step(0, 0, 3'b001, 3'b001, 8'h30, "R6 alm sec");
        set_time(10, 20, 29);
        step(0, 0, 0, 3'b010, 8'h20, "R6 alm min");
        step(0, 0, 0, 3'b100, 8'h10, "R6 alm hr");
        step(1, 0, 0, 0, 0, "R6 hit");
        chk("R6 hit", alm_flag, 1);
        step(1, 0, 0, 0, 0, "R6 miss");
        chk("R6 miss", alm_flag, 0);

        // R7 all wildcards
        step(0, 0, 0, 3'b111, 8'hC3, "R7 wild wr");
        for (int i = 0; i < 3; i++) begin
            step(1, 0, 0, 0, 0, "R7 every");
            chk("R7 every tick", alm_flag, 1);
        end

        // R8 hold freezes and blocks alarm
        step(1, 1, 0, 0, 0, "R8 hold");
        chk("R8 hold alm", alm_flag, 0);
        chk("R8 hold upd", upd_flag, 1);
        step(1, 1, 3'b010, 0, 8'h07, "R8 hold wr");
        chk("R8 write under hold", min_q, 8'h07);

        // R9 write wins over tick
        step(1, 0, 3'b001, 0, 8'h05, "R9 prec");
        chk("R9 write wins", sec_q, 8'h05);

        // R10 alarm hour decoded by current mode
        set_mode(0, 0);
        step(0, 0, 3'b100, 3'b100, 8'h81, "R10 setup");
        step(1, 0, 0, 0, 0, "R10 12h");
        chk("R10 12h match", alm_flag, 1);
        set_mode(0, 1);
        step(1, 0, 0, 0, 0, "R10 24h");
        chk("R10 24h nomatch", alm_flag, 0);

        // Constrained random mix
        for (int i = 0; i < 500; i++) begin
            bit tk, hd;
            bit [2:0] twe, awe;
            int wd, f;
            if ($urandom % 16 == 0) set_mode($urandom % 2, $urandom % 2);
            tk = ($urandom % 4) != 0;
            hd = ($urandom % 8) == 0;
            twe = 0; awe = 0; wd = 0;
            f = $urandom % 3;
            if ($urandom % 10 == 0) begin
                twe[f] = 1;
                wd = (f == 2) ? hout($urandom % 24, bin_mode, hr24) : enc($urandom % 60, bin_mode);
            end else if ($urandom % 6 == 0) begin
                awe[f] = 1; tk = 0;
                if ($urandom % 4 == 0) wd = 8'hC0 | ($urandom % 64);
                else if (f == 0) wd = enc((m_s + $urandom % 4) % 60, bin_mode);
                else if (f == 1) wd = enc(m_m, bin_mode);
                else wd = hout(m_h, bin_mode, hr24);
            end
            step(tk, hd, twe, awe, wd, "rand R2 R3 R4 R6 R7");
        end
        summary();
    end
endmodule